// File: doc/BRIEF.md
# Buffered UART Transmitter with Status Flags

This block is the transmit half of an asynchronous serial port. Software places one character in a single-entry holding register. On a baud tick, once the shift stage is free, the character moves into the shift stage. The shift stage then sends it on the serial line as a frame: a start bit, 5 to 8 data bits, an optional parity bit, and one or two stop bits. Each bit lasts one baud-tick interval. Baud-rate generation and register decode sit outside the block. The baud rate arrives as a one-cycle tick, and the frame format comes in on plain configuration inputs.

Two flags report progress, and each has its own interrupt request. The holding-empty flag is set whenever the holding register can take a new character. The line-done flag is set when a frame has finished and nothing is waiting behind it. Half-duplex users rely on line-done to turn the bus around. Line-done is cleared by a write-one-to-clear strobe or by an interrupt acknowledge.

The block also defers a disable. When the enable is dropped, every queued character is still sent, and only then is the line released.

Top module: `uart_tx_flagged`

## Requirements
- R1: A frame is one low start bit, then the data bits with the least significant bit first, then the stop bits at high level. The number of data bits is 5 plus `char_sel` (0 gives 5, 3 gives 8). The line is high whenever no frame is being sent.
- R2: When `par_en` is 1, one parity bit follows the last data bit and comes before the first stop bit. With `par_odd` = 0 the parity bit is the XOR of the sent data bits; with `par_odd` = 1 it is the inverse of that XOR.
- R3: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two. The format inputs are sampled on the baud tick that loads the shift stage.
- R4: A write is accepted only when `tx_enable` is 1 and the holding register is empty. Any other write is dropped and never appears on the line.
- R5: On a baud tick where the shift stage is idle or is ending its last bit, a held character moves into the shift stage, so frames can run back to back. `buf_empty` becomes 1 at that transfer.
- R6: `buf_empty` stays 1 until a write is accepted. `empty_irq` is high exactly while `buf_empty` and `empty_ie` are both 1.
- R7: `tx_done` becomes 1 on the baud tick that ends a frame, but only if the holding register was empty at that edge.
- R8: `tx_done` clears one cycle after `done_clr` or `done_ack` is high. If a set happens in the same cycle, the set wins. `done_irq` is high exactly while `tx_done` and `done_ie` are both 1.
- R9: When `tx_enable` falls, `txd_oe` stays 1 until both the shift stage and the holding register are empty. It drops on the next clock after that.
- R10: While `txd_oe` is 0, `txd` reads 1 and writes with `tx_enable` low have no effect.
- R11: During reset, `txd` = 1, `txd_oe` = 0, `buf_empty` = 1, `tx_done` = 0, and both interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| char_sel | input | SEL_W | Character length minus MIN_W |
| par_en | input | 1 | Insert a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 sends two stop bits |
| tx_enable | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| empty_ie | input | 1 | Holding-empty interrupt enable |
| done_ie | input | 1 | Line-done interrupt enable |
| done_clr | input | 1 | Write-one-to-clear for line-done |
| done_ack | input | 1 | Line-done interrupt acknowledge |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Line drive enable |
| buf_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Line-done flag |
| empty_irq | output | 1 | Holding-empty interrupt request |
| done_irq | output | 1 | Line-done interrupt request |

## Verification
The bench targets these corner cases:
- A write that arrives on the same cycle the held character leaves. A design that accepts it would send a character the requirements say is dropped.
- A baud tick that ends one frame while another character is held. If the design inserts an idle bit, the line timing shifts. If it raises `tx_done` anyway, it signals a turnaround too early.
- A disable issued with data still queued. Releasing the line early truncates frames.
- A clear or acknowledge that meets a new set in the same cycle. A design that lets the clear win loses a completion event.

Every character length is exercised with both parity senses and both stop-bit counts, so a misplaced or wrongly valued parity bit shows up as a line mismatch.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_sense_e;

   // longest frame: start + data + parity + two stops
   function automatic int unsigned frame_width(input int unsigned data_w);
      return 1 + data_w + 1 + 2;
   endfunction

   function automatic int unsigned sel_width(input int unsigned data_w, input int unsigned min_w);
      return (data_w > min_w) ? $clog2(data_w - min_w + 1) : 1;
   endfunction

endpackage

// File: rtl/uart_tx_holding.sv
`timescale 1ns/1ps
module uart_tx_holding #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tx_enable,
   input  logic              take,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   logic accept;

   // writes land only in an empty register while enabled
   assign accept = wr_en & tx_enable & ~valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else begin
         if (accept) begin
            valid <= 1'b1;
            data  <= wr_data;
         end else if (take) begin
            valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/uart_tx_framer.sv
`timescale 1ns/1ps
module uart_tx_framer #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned MIN_W       = 5,
   parameter bit          PARITY_OPT  = 1'b1,
   parameter bit          STOP2_OPT   = 1'b1,
   localparam int unsigned SEL_W      = uart_tx_pkg::sel_width(DATA_W, MIN_W),
   localparam int unsigned FRAME_W    = uart_tx_pkg::frame_width(DATA_W),
   localparam int unsigned CNT_W      = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data,
   input  logic [SEL_W-1:0]   char_sel,
   input  logic               par_en,
   input  logic               par_odd,
   input  logic               two_stop,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbits
);
   import uart_tx_pkg::*;

   logic par_on;
   logic stop2_on;
   par_sense_e sense;

   generate
      if (PARITY_OPT) begin : g_par
         assign par_on = par_en;
         assign sense  = par_odd ? PAR_ODD : PAR_EVEN;
      end else begin : g_nopar
         assign par_on = 1'b0;
         assign sense  = PAR_EVEN;
      end
      if (STOP2_OPT) begin : g_stop2
         assign stop2_on = two_stop;
      end else begin : g_stop1
         assign stop2_on = 1'b0;
      end
   endgenerate

   int unsigned len;
   logic        acc;

   always_comb begin
      len = MIN_W + int'(char_sel);
      if (len > DATA_W) len = DATA_W;
      frame    = '1;          // stop bits and unused tail stay high
      frame[0] = 1'b0;        // start bit
      acc      = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(len)) begin
            frame[1 + i] = data[i];
            acc          = acc ^ data[i];
         end
      end
      if (par_on) frame[1 + len] = acc ^ (sense == PAR_ODD);
      nbits = CNT_W'(1 + len + (par_on ? 1 : 0) + (stop2_on ? 2 : 1));
   end
endmodule

// File: rtl/uart_tx_shifter.sv
`timescale 1ns/1ps
module uart_tx_shifter #(
   parameter int unsigned FRAME_W = 12,
   localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               have_data,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   nbits,
   output logic               take,
   output logic               frame_end,
   output logic               busy,
   output logic               line
);
   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   cnt;
   logic               last;

   assign last      = busy & (cnt == CNT_W'(1));
   assign frame_end = tick & last;
   assign take      = tick & have_data & (~busy | last);
   assign line      = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         cnt  <= '0;
         busy <= 1'b0;
      end else if (tick) begin
         if (take) begin
            sh   <= frame;
            cnt  <= nbits;
            busy <= 1'b1;
         end else if (last) begin
            sh   <= '1;
            cnt  <= '0;
            busy <= 1'b0;
         end else if (busy) begin
            sh  <= {1'b1, sh[FRAME_W-1:1]};
            cnt <= cnt - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/uart_tx_status.sv
`timescale 1ns/1ps
module uart_tx_status (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_end,
   input  logic take,
   input  logic busy,
   input  logic buf_valid,
   input  logic tx_enable,
   input  logic done_clr,
   input  logic done_ack,
   input  logic empty_ie,
   input  logic done_ie,
   output logic tx_done,
   output logic active,
   output logic empty_irq,
   output logic done_irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_done <= 1'b0;
      end else if (frame_end & ~take) begin
         tx_done <= 1'b1;
      end else if (done_clr | done_ack) begin
         tx_done <= 1'b0;
      end
   end

   // enable is taken at once; disable waits until nothing is queued
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
      end else if (tx_enable) begin
         active <= 1'b1;
      end else if (~busy & ~buf_valid) begin
         active <= 1'b0;
      end
   end

   assign empty_irq = ~buf_valid & empty_ie;
   assign done_irq  = tx_done & done_ie;
endmodule

// File: rtl/uart_tx_flagged.sv
`timescale 1ns/1ps
module uart_tx_flagged #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned MIN_W      = 5,
   parameter bit          PARITY_OPT = 1'b1,
   parameter bit          STOP2_OPT  = 1'b1,
   localparam int unsigned SEL_W     = uart_tx_pkg::sel_width(DATA_W, MIN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  char_sel,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              tx_enable,
   input  logic              baud_tick,
   input  logic              empty_ie,
   input  logic              done_ie,
   input  logic              done_clr,
   input  logic              done_ack,
   output logic              txd,
   output logic              txd_oe,
   output logic              buf_empty,
   output logic              tx_done,
   output logic              empty_irq,
   output logic              done_irq
);
   localparam int unsigned FRAME_W = uart_tx_pkg::frame_width(DATA_W);
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (MIN_W < 1 || DATA_W < MIN_W) begin : g_bad_width
         $fatal(1, "uart_tx_flagged: need 1 <= MIN_W <= DATA_W");
      end
   endgenerate

   logic               buf_valid;
   logic [DATA_W-1:0]  buf_data;
   logic               take;
   logic               frame_end;
   logic               busy;
   logic               line;
   logic               active;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;

   uart_tx_holding #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .tx_enable (tx_enable),
      .take      (take),
      .valid     (buf_valid),
      .data      (buf_data)
   );

   uart_tx_framer #(
      .DATA_W     (DATA_W),
      .MIN_W      (MIN_W),
      .PARITY_OPT (PARITY_OPT),
      .STOP2_OPT  (STOP2_OPT)
   ) u_framer (
      .data     (buf_data),
      .char_sel (char_sel),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .two_stop (two_stop),
      .frame    (frame),
      .nbits    (nbits)
   );

   uart_tx_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .have_data (buf_valid),
      .frame     (frame),
      .nbits     (nbits),
      .take      (take),
      .frame_end (frame_end),
      .busy      (busy),
      .line      (line)
   );

   uart_tx_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .take      (take),
      .busy      (busy),
      .buf_valid (buf_valid),
      .tx_enable (tx_enable),
      .done_clr  (done_clr),
      .done_ack  (done_ack),
      .empty_ie  (empty_ie),
      .done_ie   (done_ie),
      .tx_done   (tx_done),
      .active    (active),
      .empty_irq (empty_irq),
      .done_irq  (done_irq)
   );

   assign buf_empty = ~buf_valid;
   assign txd_oe    = active;
   assign txd       = active ? line : 1'b1;
endmodule

// File: rtl/uart_tx_flagged_sva.sv
`timescale 1ns/1ps
module uart_tx_flagged_sva (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic tx_enable,
   input logic done_clr,
   input logic done_ack,
   input logic txd,
   input logic txd_oe,
   input logic buf_empty,
   input logic tx_done,
   input logic busy,
   input logic frame_end
);
   assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);

   assert_empty_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_empty && !(wr_en && tx_enable) |=> buf_empty);

   assert_done_idle_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> (txd && !busy));

   assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done && !done_clr && !done_ack |=> tx_done);

   assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_clr || done_ack) && !frame_end |=> !tx_done);

   assert_drain_keeps_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      txd_oe && (busy || !buf_empty) |=> txd_oe);

   assert_released_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !txd_oe |-> txd);
endmodule

bind uart_tx_flagged uart_tx_flagged_sva u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .tx_enable (tx_enable),
   .done_clr  (done_clr),
   .done_ack  (done_ack),
   .txd       (txd),
   .txd_oe    (txd_oe),
   .buf_empty (buf_empty),
   .tx_done   (tx_done),
   .busy      (busy),
   .frame_end (frame_end)
);

// File: tb/uart_tx_flagged_bench.sv
`timescale 1ns/1ps
module uart_tx_flagged_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] char_sel = 2'd3;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       two_stop = 1'b0;
   logic       tx_enable = 1'b0;
   logic       baud_tick = 1'b0;
   logic       empty_ie = 1'b0;
   logic       done_ie = 1'b0;
   logic       done_clr = 1'b0;
   logic       done_ack = 1'b0;
   logic       txd, txd_oe, buf_empty, tx_done, empty_irq, done_irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   uart_tx_flagged u_uart_tx_flagged (
      .clk, .rst_n, .wr_en, .wr_data, .char_sel, .par_en, .par_odd,
      .two_stop, .tx_enable, .baud_tick, .empty_ie, .done_ie, .done_clr,
      .done_ack, .txd, .txd_oe, .buf_empty, .tx_done, .empty_irq, .done_irq
   );

   // reference: pending line bits as a queue, head is the bit on the line
   bit       q[$];
   bit       m_valid = 0;
   bit [7:0] m_data = '0;
   bit       m_done = 0;
   bit       m_act = 0;
   bit       acc_v, end_v, take_v, idle_v;

   function automatic void push_frame(input bit [7:0] d);
      int len = 5 + int'(char_sel);
      bit p = 0;
      q.push_back(1'b0);
      for (int i = 0; i < len; i++) begin
         q.push_back(d[i]);
         p ^= d[i];
      end
      if (par_en) q.push_back(p ^ par_odd);
      q.push_back(1'b1);
      if (two_stop) q.push_back(1'b1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_valid = 0; m_done = 0; m_act = 0;
      end else begin
         acc_v  = wr_en && tx_enable && !m_valid;
         idle_v = (q.size() == 0) && !m_valid;
         end_v  = 0;
         take_v = 0;
         if (baud_tick) begin
            if (q.size() > 0) begin
               void'(q.pop_front());
               if (q.size() == 0) end_v = 1;
            end
            if (q.size() == 0 && m_valid) begin
               push_frame(m_data);
               m_valid = 0;
               take_v  = 1;
            end
         end
         if (acc_v) begin
            m_valid = 1;
            m_data  = wr_data;
         end
         if (end_v && !take_v) m_done = 1;
         else if (done_clr || done_ack) m_done = 0;
         if (tx_enable) m_act = 1;
         else if (idle_v) m_act = 0;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R1/R2/R3 txd", txd, (q.size() > 0) ? q[0] : 1'b1);
      chk("R9/R10 txd_oe", txd_oe, m_act);
      chk("R4/R5/R6 buf_empty", buf_empty, !m_valid);
      chk("R7/R8 tx_done", tx_done, m_done);
      chk("R6 empty_irq", empty_irq, !m_valid && empty_ie);
      chk("R8 done_irq", done_irq, m_done && done_ie);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      compare();
      wr_en = 0; baud_tick = 0; done_clr = 0; done_ack = 0;
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         baud_tick = (i % 2 == 0);
         step();
      end
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11 txd", txd, 1'b1);
      chk("R11 txd_oe", txd_oe, 1'b0);
      chk("R11 buf_empty", buf_empty, 1'b1);
      chk("R11 tx_done", tx_done, 1'b0);
      chk("R11 irqs", empty_irq | done_irq, 1'b0);
      rst_n = 1;
      step();

      // R4/R10: write while disabled is dropped
      wr_en = 1; wr_data = 8'h5A; step(); step();
      chk("R10 write while disabled", buf_empty, 1'b1);

      // R1/R5: 8N1 frame, second write while full dropped
      tx_enable = 1; empty_ie = 1; done_ie = 1; step();
      wr_en = 1; wr_data = 8'hA5; step();
      chk("R4 accepted write", buf_empty, 1'b0);
      wr_en = 1; wr_data = 8'h3C; step();
      run_ticks(40);
      chk("R7 done after drain", tx_done, 1'b1);
      done_ack = 1; step();
      chk("R8 ack clears", tx_done, 1'b0);

      // R2/R3: 5-bit odd parity, two stops, back to back
      char_sel = 0; par_en = 1; par_odd = 1; two_stop = 1;
      wr_en = 1; wr_data = 8'h13; step();
      baud_tick = 1; step();
      wr_en = 1; wr_data = 8'h0E; step();
      run_ticks(6);
      par_odd = 0; char_sel = 2;
      run_ticks(40);
      done_clr = 1; step();
      chk("R8 clear strobe", tx_done, 1'b0);

      // R9: disable with data queued
      wr_en = 1; wr_data = 8'hC3; step();
      baud_tick = 1; step();
      wr_en = 1; wr_data = 8'h7E; step();
      tx_enable = 0; step();
      chk("R9 oe held while draining", txd_oe, 1'b1);
      run_ticks(60);
      chk("R9 oe released after drain", txd_oe, 1'b0);
      wr_en = 1; wr_data = 8'hFF; step();
      chk("R10 disabled write ignored", buf_empty, 1'b1);
      chk("R10 released line high", txd, 1'b1);

      // random phase
      tx_enable = 1;
      for (int n = 0; n < 6000; n++) begin
         baud_tick = ($urandom % 3) == 0;
         wr_en     = ($urandom % 4) == 0;
         wr_data   = 8'($urandom);
         if (($urandom % 16) == 0) begin
            char_sel = 2'($urandom); par_en = 1'($urandom);
            par_odd = 1'($urandom); two_stop = 1'($urandom);
         end
         if (($urandom % 150) == 0) tx_enable = ~tx_enable;
         empty_ie = ($urandom % 4) != 0;
         done_ie  = ($urandom % 4) != 0;
         done_clr = ($urandom % 20) == 0;
         done_ack = ($urandom % 20) == 0;
         step();
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5678));
   end
endmodule